// File: doc/BRIEF.md
# External Bus Wait-State Sequencer

This block steps one external memory access through its clock phases. Each phase takes one clock. An access runs T0, T1 and T2, then zero or more wait pairs, then T3, and then returns to T0. A wait pair is one Tw phase followed by a repeated T2 phase. Address drivers, data drivers and pad control follow the phase output. They sit outside this block.

Two sources set the number of wait pairs, and the larger of the two applies. The first is a 4-bit count from the bus control register. It is captured when the access is accepted. The second is an active-low transfer-acknowledge input. A cycle ends only once the programmed pairs are used up and the acknowledge has been seen at a T2 edge. When the programmed count is zero and the acknowledge is already low at the edge that accepts the access, the cycle runs with no waits at all.

Top module: `wsq_top`

## Requirements
- R1: While reset is active and right after it, `phase` is 0 (T0), `busy` is 0 and `done` is 0.
- R2: A `start` is accepted only at a clock edge where the block is idle (`phase` = 0, `busy` = 0). The phase is 1 (T1) one clock later. A `start` that is held during an active cycle changes nothing.
- R3: Phase codes are T0 = 0, T1 = 1, T2 = 2, T3 = 3 and Tw = 4. An active cycle follows the order T1, T2, then any number of (Tw, T2) pairs, then T3, then idle T0. The busy part of a cycle with N waits lasts 3 + 2N clocks.
- R4: With a nonzero register count W, the number of Tw phases is max(W, K). K is the index, counted from 0, of the first T2 at whose closing edge `ta_n` is sampled low, given that `ta_n` stays low on later T2 phases. An acknowledge that comes before the last programmed T2 adds nothing.
- R5: With W = 0 and `ta_n` low at the accepting edge, the cycle has no Tw phases, whatever `ta_n` is during T2.
- R6: With W = 0 and `ta_n` high at the accepting edge, a Tw pair is added for every T2 that closes with `ta_n` high. The cycle ends after the first T2 that closes with `ta_n` low.
- R7: `done` is 1 for exactly one clock, the clock right after T3. It is 0 at all other times. `busy` is 1 in T1, T2, Tw and T3.
- R8: The register count is captured at the accepting edge. Changing `wait_cnt` later in the cycle does not change that cycle's wait count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one phase per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to begin an access; taken only when idle |
| wait_cnt | input | CNT_W (4) | Programmed wait pair count |
| ta_n | input | 1 | Transfer acknowledge, active low, synchronous to clk |
| phase | output | 3 | Current phase code (0 T0, 1 T1, 2 T2, 3 T3, 4 Tw) |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-clock pulse after T3 |

## Verification
The properties assume that `ta_n` has already been synchronised to `clk`, and that `start` and `wait_cnt` change only between edges. The stimulus keeps to this because every input change happens on the falling edge. The stimulus assumes the acknowledge source behaves like a memory that stays ready once it is ready. For that reason the bench drives `ta_n` low on every T2 from index K on, and high in T3 and the other phases. This matches the convention that the acknowledge is released before the next T0. The sweep also holds `start` high during some busy cycles and changes `wait_cnt` in the middle of some cycles, so that both of these can be seen at the ports.

// File: rtl/wsq_pkg.sv
package wsq_pkg;
    typedef enum logic [2:0] {
        PH_T0 = 3'd0,
        PH_T1 = 3'd1,
        PH_T2 = 3'd2,
        PH_T3 = 3'd3,
        PH_TW = 3'd4
    } phase_e;
endpackage

// File: rtl/wsq_wait_track.sv
// Holds the wait pairs still owed to the register count, and the
// early-acknowledge flag captured at the accepting edge.
module wsq_wait_track #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] wcnt,
    input  logic             ta_n,
    input  logic             consume,
    output logic             left_zero,
    output logic             early_ack
);
    typedef struct packed {
        logic [CNT_W-1:0] left;
        logic             early;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (load) begin
            trk_d.left  = wcnt;
            // A zero count with the acknowledge already low means no waits at all.
            trk_d.early = (wcnt == '0) && !ta_n;
        end else if (consume) begin
            trk_d.left = trk_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign left_zero = (trk_q.left == '0);
    assign early_ack = trk_q.early;
endmodule

// File: rtl/wsq_top.sv
module wsq_top #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] wait_cnt,
    input  logic             ta_n,
    output logic [2:0]       phase,
    output logic             busy,
    output logic             done
);
    import wsq_pkg::*;

    typedef struct packed {
        phase_e ph;
        logic   done;
    } seq_t;

    seq_t seq_d, seq_q;
    logic load, consume, left_zero, early_ack;

    assign load    = (seq_q.ph == PH_T0) && start;
    assign consume = (seq_q.ph == PH_T2) && !left_zero;

    wsq_wait_track #(.CNT_W(CNT_W)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .wcnt      (wait_cnt),
        .ta_n      (ta_n),
        .consume   (consume),
        .left_zero (left_zero),
        .early_ack (early_ack)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = (seq_q.ph == PH_T3);
        unique case (seq_q.ph)
            PH_T0: if (start) seq_d.ph = PH_T1;
            PH_T1: seq_d.ph = PH_T2;
            PH_T2: begin
                if (!left_zero)              seq_d.ph = PH_TW;
                else if (early_ack || !ta_n) seq_d.ph = PH_T3;
                else                         seq_d.ph = PH_TW;
            end
            PH_TW: seq_d.ph = PH_T2;
            PH_T3: seq_d.ph = PH_T0;
            default: seq_d.ph = PH_T0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{ph: PH_T0, done: 1'b0};
        else        seq_q <= seq_d;
    end

    assign phase = seq_q.ph;
    assign busy  = (seq_q.ph != PH_T0);
    assign done  = seq_q.done;
endmodule

// File: rtl/wsq_checker.sv
module wsq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [2:0] phase,
    input logic       busy,
    input logic       done
);
    p_t1_to_t2_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd1) |=> (phase == 3'd2));
    p_tw_to_t2_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd4) |=> (phase == 3'd2));
    p_t2_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd2) |=> (phase == 3'd4 || phase == 3'd3));
    p_t3_to_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd3) |=> (phase == 3'd0 && !busy));
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd0 && start) |=> (phase == 3'd1 && busy));
    p_no_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != 3'd0) |=> (phase != 3'd1));
    p_done_after_t3_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd3) |=> done);
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (phase != 3'd2 && phase != 3'd4));
endmodule

bind wsq_top wsq_checker u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .phase (phase),
    .busy  (busy),
    .done  (done)
);

// File: tb/sim_wsq_top.sv
`timescale 1ns/1ps
module sim_wsq_top;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [CW-1:0] wait_cnt;
    logic          ta_n;
    logic [2:0]    phase;
    logic          busy;
    logic          done;

    always #2.5 clk = ~clk;

    wsq_top #(.CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .wait_cnt(wait_cnt),
        .ta_n(ta_n), .phase(phase), .busy(busy), .done(done)
    );

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit legal(input int a, input int b);
        return (a == 1 && b == 2) || (a == 2 && (b == 4 || b == 3)) ||
               (a == 4 && b == 2) || (a == 3 && b == 0);
    endfunction

    // One access: w = register count, k = first T2 index with ta_n low,
    // early = ta_n low at the accepting edge, hold = keep start high while busy,
    // chg = alter wait_cnt after acceptance.
    task automatic run_bus(input int w, input int k, input bit early,
                           input bit hold, input bit chg);
        int t2i = 0, tw = 0, len = 0, bad = 0, dn = 0, guard = 0, prev, exp_w;
        logic [CW-1:0] wv;
        string tag;
        wv    = CW'(w);
        exp_w = (w > 0) ? ((k > w) ? k : w) : (early ? 0 : k);
        tag   = (w > 0) ? "R4" : (early ? "R5" : "R6");
        if (chg) tag = {tag, "/R8"};
        @(negedge clk);
        wait_cnt = wv; start = 1'b1; ta_n = !early;
        @(negedge clk);
        start = hold; ta_n = 1'b1;
        if (chg) wait_cnt = ~wv;
        chk(phase == 3'd1 && busy, "R2 accept to T1", int'(phase), 1);
        while (phase != 3'd0 && guard < 200) begin
            len++; guard++;
            if (done)        dn++;
            if (phase == 3'd4) tw++;
            if (phase == 3'd2) begin
                ta_n = (t2i >= k) ? 1'b0 : 1'b1;
                t2i++;
            end else begin
                ta_n = 1'b1;
            end
            prev = int'(phase);
            @(negedge clk);
            if (!legal(prev, int'(phase))) bad++;
        end
        start = 1'b0; ta_n = 1'b1;
        chk(guard < 200, "R3 cycle terminates", guard, len);
        chk(tw == exp_w, {tag, " wait count"}, tw, exp_w);
        chk(len == 3 + 2 * exp_w, "R3 busy length", len, 3 + 2 * exp_w);
        chk(bad == 0, "R3 phase order", bad, 0);
        chk(done == 1'b1 && dn == 0 && !busy, "R7 done after T3", int'(done), 1);
        if (hold) chk(phase == 3'd0, "R2 held start ignored while busy", int'(phase), 0);
        @(negedge clk);
        chk(done == 1'b0 && phase == 3'd0, "R7 done single pulse", int'(done), 0);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; ta_n = 1'b1; wait_cnt = '0;
        repeat (3) @(negedge clk);
        chk(phase == 3'd0 && !busy && !done, "R1 reset state", int'(phase), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(phase == 3'd0 && !busy && !done, "R1 idle after reset", int'(phase), 0);
        for (int w = 0; w < 16; w++) begin
            for (int k = 0; k < 18; k++) begin
                for (int e = 0; e < 2; e++) begin
                    run_bus(w, k, e[0], (k % 3) == 1, ((k + e) % 4) == 2);
                end
            end
        end
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 190000);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule